// File: doc/BRIEF.md
# Reaction Timer Game Controller

This block runs a reaction-time game. A press on the start button loads a pseudo-random wait of zero to three seconds, drawn from a free-running 5-bit linear feedback shift register. When the wait has run out, the LED output turns on. The block then counts milliseconds until the player presses the response button. It reports the measured time and classifies it as fast, good or slow. The result stays on the outputs until the next start press.

The block contains two tick generators. The seconds divider paces the wait, and the millisecond divider paces the response count. Both are parameters, so a simulation can run with short ticks. Button inputs are assumed to be clean and synchronous. Debouncing and display decoding sit outside the block.

Top module: `reaction_timer`

## Requirements
- R1: The random source is a 5-bit register preset to 5'b11111 by reset. Each clock it shifts toward bit 0, and the new bit 4 is bit 2 XOR bit 0. It therefore cycles through all 31 nonzero states.
- R2: On a clock edge where start_i is high, the wait length in seconds is loaded from random-source bits {bit 3, bit 1} as they stood before that edge.
- R3: The seconds tick occurs once every SEC_CYCLES clocks. The wrap happens at terminal count SEC_CYCLES-1, which is 0x5F5E0FF by default. The divider is cleared by reset and on every edge where start_i is high. For a loaded wait w ≥ 1, the LED lights exactly w·SEC_CYCLES clocks after the last start edge.
- R4: Reset sets the wait counter to 3, and it does not count until a start has been registered. Counting happens only while the LED is off, and the counter stops at 0 without wrapping.
- R5: led_o is high exactly when the wait counter is zero and start_i is low. A zero wait lights the LED as soon as start is released. Once lit, the LED stays lit until start_i or reset.
- R6: After the LED lights, resp_ms_o counts one step per MS_CYCLES clocks. A response captured d clocks after the LED-lighting edge reports floor(d/MS_CYCLES).
- R7: The response count saturates at 1023.
- R8: class_o encodes the result. 2'b00 means fast (below 250), 2'b01 means good (250 to 499), 2'b10 means slow (500 and above), and 2'b11 means no result (after reset or start).
- R9: A response press while a wait is in progress is an early press. It gives class 2'b10 with resp_ms_o = 0. A press before any start has no effect.
- R10: The first captured result holds through later response presses and through the LED lighting. The next start press clears it to class 2'b11 and count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start button, loads a random wait |
| resp_i | input | 1 | Player response button |
| led_o | output | 1 | Go signal for the player |
| resp_ms_o | output | RESP_W | Measured response in milliseconds |
| class_o | output | 2 | Result class code |

## Verification
The bench sweeps start presses across more than a full LFSR period and times each LED rise to the exact cycle. A wrong tap, a swapped wait bit or a divider that is not restarted by start would shift that count. Response presses are placed on both sides of each threshold and past saturation. A design with an off-by-one boundary or a wrapping counter would misreport class or value there. Early presses, repeated presses, and start held while the LED is lit are also exercised, since a design that re-captured or failed to gate the LED would show a changed result or a lit LED.

// File: rtl/rt_pkg.sv
package rt_pkg;
  typedef enum logic [1:0] {
    CLS_FAST = 2'b00,
    CLS_GOOD = 2'b01,
    CLS_SLOW = 2'b10,
    CLS_NONE = 2'b11
  } rt_class_e;
endpackage

// File: rtl/rt_lfsr.sv
module rt_lfsr #(
  parameter int W     = 5,
  parameter int TAP   = 2,
  parameter int OUT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] pick_o
);
  logic [W-1:0] state_q, state_d;

  always_comb begin
    state_d = {state_q[TAP] ^ state_q[0], state_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '1;
    else        state_q <= state_d;
  end

  // odd bits feed the wait value: bit 2k+1 -> output bit k
  for (genvar k = 0; k < OUT_W; k++) begin : g_pick
    assign pick_o[k] = state_q[2*k+1];
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R1
endmodule

// File: rtl/rt_tick_div.sv
module rt_tick_div #(
  parameter int TERM = 99_999_999
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (TERM < 1) ? 1 : $clog2(TERM + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == CW'(TERM));

  always_comb begin
    if (clr_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TERM)); // R3
  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0); // R3
endmodule

// File: rtl/rt_down_cnt.sv
module rt_down_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)               cnt_d = data_i;
    else if (en_i && !zero_o) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  AST_DCNT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o && !load_i |=> zero_o); // R4
  AST_DCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i && en_i && !zero_o |=> cnt_q == $past(cnt_q) - W'(1)); // R4
endmodule

// File: rtl/rt_resp_timer.sv
module rt_resp_timer
  import rt_pkg::*;
#(
  parameter int CW      = 10,
  parameter int FAST_LT = 250,
  parameter int GOOD_LT = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          lit_i,
  input  logic          waiting_i,
  input  logic          tick_i,
  input  logic          press_i,
  output logic [CW-1:0] ms_o,
  output rt_class_e     class_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  rt_class_e     cls_q, cls_d, cls_live;

  always_comb begin
    if (cnt_q < CW'(FAST_LT))      cls_live = CLS_FAST;
    else if (cnt_q < CW'(GOOD_LT)) cls_live = CLS_GOOD;
    else                           cls_live = CLS_SLOW;
  end

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    cls_d  = cls_q;
    if (clr_i) begin
      cnt_d  = '0;
      done_d = 1'b0;
      cls_d  = CLS_NONE;
    end else if (!done_q && press_i && lit_i) begin
      done_d = 1'b1;
      cls_d  = cls_live;
    end else if (!done_q && press_i && waiting_i) begin
      done_d = 1'b1;
      cls_d  = CLS_SLOW;
    end else if (!done_q && lit_i && tick_i && cnt_q != '1) begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      cls_q  <= CLS_NONE;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      cls_q  <= cls_d;
    end
  end

  assign ms_o    = cnt_q;
  assign class_o = cls_q;

  AST_RESP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> cnt_q >= $past(cnt_q)); // R7
  AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !clr_i |=> $stable(cnt_q) && $stable(cls_q)); // R10
  AST_RESP_FAST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && cls_q == CLS_FAST |-> cnt_q < CW'(FAST_LT)); // R8
endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
  import rt_pkg::*;
#(
  parameter int SEC_CYCLES = 100_000_000,
  parameter int MS_CYCLES  = 100_000,
  parameter int LFSR_W     = 5,
  parameter int LFSR_TAP   = 2,
  parameter int WAIT_W     = 2,
  parameter int RESP_W     = 10,
  parameter int FAST_MS    = 250,
  parameter int GOOD_MS    = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              resp_i,
  output logic              led_o,
  output logic [RESP_W-1:0] resp_ms_o,
  output logic [1:0]        class_o
);
  localparam int SEC_TERM = SEC_CYCLES - 1;
  localparam int MS_TERM  = MS_CYCLES - 1;

  logic [WAIT_W-1:0] rand_wait;
  logic [WAIT_W-1:0] wait_cnt;
  logic              wait_zero;
  logic              sec_tick, ms_tick;
  logic              armed_q, armed_d;
  logic              cnt_en;
  rt_class_e         cls;

  rt_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP), .OUT_W(WAIT_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .pick_o(rand_wait)
  );

  rt_tick_div #(.TERM(SEC_TERM)) u_sec_div (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .tick_o(sec_tick)
  );

  rt_tick_div #(.TERM(MS_TERM)) u_ms_div (
    .clk(clk), .rst_n(rst_n), .clr_i(!led_o), .tick_o(ms_tick)
  );

  // sticky flag: a start has been seen since reset
  always_comb armed_d = armed_q | start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign led_o  = wait_zero & ~start_i;
  assign cnt_en = armed_q & ~led_o & sec_tick;

  rt_down_cnt #(.W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load_i(start_i), .data_i(rand_wait),
    .en_i(cnt_en), .cnt_o(wait_cnt), .zero_o(wait_zero)
  );

  rt_resp_timer #(.CW(RESP_W), .FAST_LT(FAST_MS), .GOOD_LT(GOOD_MS)) u_resp (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .lit_i(led_o),
    .waiting_i(armed_q & ~wait_zero & ~start_i), .tick_i(ms_tick),
    .press_i(resp_i), .ms_o(resp_ms_o), .class_o(cls)
  );

  assign class_o = cls;

  AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(led_o) && !start_i |-> led_o); // R5
  AST_NO_COUNT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q && !start_i |=> wait_cnt == $past(wait_cnt)); // R4
endmodule

// File: tb/sim_reaction_timer.sv
module sim_reaction_timer;
  localparam int SEC = 4;
  localparam int MSC = 2;

  logic       clk, rst_n, start_i, resp_i;
  logic       led_o;
  logic [9:0] resp_ms_o;
  logic [1:0] class_o;
  logic [4:0] m;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  reaction_timer #(.SEC_CYCLES(SEC), .MS_CYCLES(MSC)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .resp_i(resp_i),
    .led_o(led_o), .resp_ms_o(resp_ms_o), .class_o(class_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // reference random source from R1
  always @(posedge clk or negedge rst_n)
    if (!rst_n) m <= 5'h1F;
    else        m <= {m[2] ^ m[0], m[4:1]};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      report();
    end
  end

  task automatic press_start(output int w);
    @(negedge clk);
    start_i = 1'b1;
    w = {m[3], m[1]};
    @(negedge clk);
    start_i = 1'b0;
    #1;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!led_o && n < 64) begin
      @(negedge clk); #1; n++;
    end
  endtask

  task automatic resp_trial(input int d);
    int w, n, expv, expc;
    press_start(w);
    measure(n);
    chk("R3 wait before response", n, w * SEC);
    repeat (d) @(negedge clk);
    resp_i = 1'b1;
    @(negedge clk);
    resp_i = 1'b0;
    #1;
    expv = d / MSC;
    if (expv > 1023) expv = 1023;
    expc = (expv < 250) ? 0 : (expv < 500) ? 1 : 2;
    chk("R6 R7 response value", int'(resp_ms_o), expv);
    chk("R8 response class", int'(class_o), expc);
  endtask

  initial begin
    int w, n, w2;
    rst_n = 1'b0; start_i = 1'b0; resp_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state
    chk("R4 reset led", int'(led_o), 0);
    chk("R8 reset class none", int'(class_o), 3);
    chk("R6 reset value", int'(resp_ms_o), 0);
    repeat (30) @(negedge clk);
    #1;
    chk("R4 no count before start", int'(led_o), 0);
    // press before any start is ignored
    resp_i = 1'b1; @(negedge clk); resp_i = 1'b0; #1;
    chk("R9 idle press ignored class", int'(class_o), 3);

    // sweep over more than one period of the random source
    for (int t = 0; t < 40; t++) begin
      press_start(w);
      measure(n);
      chk("R1 R2 R3 wait length", n, w * SEC);
      repeat (t % 3) @(negedge clk);
    end

    // LED stays lit, counter stopped at zero
    repeat (40) @(negedge clk);
    #1;
    chk("R4 R5 led stays lit", int'(led_o), 1);
    // start held gates the LED
    @(negedge clk); start_i = 1'b1; #1;
    chk("R5 led gated by start", int'(led_o), 0);
    @(negedge clk); #1;
    chk("R5 led gated by start held", int'(led_o), 0);
    chk("R10 start clears class", int'(class_o), 3);
    start_i = 1'b0;
    measure(n);

    // restart of the seconds divider mid-wait
    w = 0;
    while (w == 0) press_start(w);
    repeat (2) @(negedge clk);
    press_start(w2);
    measure(n);
    chk("R3 restart on second start", n, w2 * SEC);

    // response thresholds and saturation
    resp_trial(0);
    resp_trial(499);
    resp_trial(500);
    resp_trial(999);
    resp_trial(1000);
    resp_trial(1999);
    resp_trial(2100);
    chk("R7 saturated value", int'(resp_ms_o), 1023);

    // result held against later presses
    repeat (5) @(negedge clk);
    resp_i = 1'b1; @(negedge clk); resp_i = 1'b0; #1;
    chk("R10 repeat press value held", int'(resp_ms_o), 1023);
    chk("R10 repeat press class held", int'(class_o), 2);

    // early press
    w = 0;
    while (w == 0) press_start(w);
    chk("R10 start clears value", int'(resp_ms_o), 0);
    resp_i = 1'b1; @(negedge clk); resp_i = 1'b0; #1;
    chk("R9 early press class", int'(class_o), 2);
    chk("R9 early press value", int'(resp_ms_o), 0);
    measure(n);
    chk("R5 led after early press", int'(led_o), 1);
    repeat (20) @(negedge clk);
    resp_i = 1'b1; @(negedge clk); resp_i = 1'b0; #1;
    chk("R10 early result held class", int'(class_o), 2);
    chk("R10 early result held value", int'(resp_ms_o), 0);

    report();
  end
endmodule